// File: doc/BRIEF.md
# Sequential Miss Stream Prefetcher

This block watches the line addresses of data cache misses and looks for sequential streams. A stream can run upward or downward. When two misses land on neighbouring lines of the same page, the block opens a stream in a table of tracked streams. It then issues prefetch requests that run ahead of the demand point at two levels. The first-level cache is kept a fixed two lines ahead. The second-level cache is kept ahead by a programmable depth, capped at 24 lines. Store streams never fill the first level.

Demand touches on a stream's next line move the stream forward. Software can open a stream in a chosen slot, with its own direction, level policy and depth, or close one. A stream never crosses into another page. When the table is full, a new stream evicts the least recently used one. Requests leave through a registered valid/ready port. Each line is handed out once per level, and a request stays on the port until it is accepted.

Top module: `pf_stream_engine`

## Requirements
- R1: After reset the table is empty and `pf_valid` is low. No request appears until a stream exists.
- R2: Two misses are needed to open a stream. A miss to line M-1 followed by a miss to line M, both in one page, opens an ascending stream with head M. A miss to M+1 followed by M opens a descending stream. A lone miss, or a miss two lines away from an earlier one, opens nothing.
- R3: A load stream with head H and step s (+1 ascending, -1 descending) first requests H+s and H+2s with `pf_l2`=0. It then requests H+s through H+D·s with `pf_l2`=1, where D is the stream's depth limited to 24. Hardware-opened streams take D from `cfg_l2_depth`.
- R4: A stream opened with the store flag set issues only `pf_l2`=1 requests.
- R5: A page is 32 lines, so the line number bits above bit 4 select the page. No request targets a line outside the head's page. A pair of misses whose second line is the last line of the page in the stream's direction opens nothing, and a pair that straddles two pages opens nothing. A touch that moves the head onto that last line ends the stream.
- R6: A touch on line H+s moves the head to H+s. Each level then issues only the one line that restores its lead. No line is requested twice at the same level, and a touch on any other line has no effect.
- R7: While `pf_valid` is high and `pf_ready` is low, `pf_valid`, `pf_line` and `pf_l2` hold their values.
- R8: A software start (`sw_start`=1) puts a stream into slot `sw_slot` with head `sw_line`, direction `sw_desc` (1 = descending), store flag `sw_store` and depth `sw_len` limited to 24. A software command takes precedence over a miss allocation in the same cycle.
- R9: A software end (`sw_start`=0) clears slot `sw_slot`. The stream in that slot then issues nothing further, and touches on it have no effect.
- R10: When all 16 slots are in use, a newly detected stream replaces the slot that was least recently started, allocated or touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_l2_depth | input | 5 | Second-level depth for streams opened from misses |
| miss_valid | input | 1 | Miss event strobe |
| miss_line | input | 25 | Line address of the miss |
| miss_store | input | 1 | Miss was caused by a store |
| touch_valid | input | 1 | Demand touch strobe |
| touch_line | input | 25 | Line address touched by demand |
| sw_valid | input | 1 | Software command strobe |
| sw_start | input | 1 | 1 = open stream, 0 = close stream |
| sw_slot | input | 4 | Table slot addressed by the command |
| sw_desc | input | 1 | Direction for a start, 1 = descending |
| sw_store | input | 1 | Store-stream flag for a start |
| sw_line | input | 25 | Head line for a start |
| sw_len | input | 5 | Second-level depth for a start |
| pf_ready | input | 1 | Consumer accepts the request |
| pf_valid | output | 1 | Prefetch request valid |
| pf_line | output | 25 | Line address to prefetch |
| pf_l2 | output | 1 | Target level, 0 = first level, 1 = second level |

## Verification
A wrong lead counter shows up on the port within a few cycles. It appears either as a line requested twice at one level or as a gap in the ascending or descending run that follows a touch. A wrong head or direction shows up as a touch that produces nothing, or as a request that lands outside the page. A slip in the replacement ages only shows up after the table has filled. For that reason the tests touch streams after an eviction and check that the evicted stream has gone silent while its neighbours still respond.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {LVL_L1 = 1'b0, LVL_L2 = 1'b1} pf_level_e;
endpackage

// File: rtl/pf_pick.sv
module pf_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
)(
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/pf_lru.sv
module pf_lru #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          use_v,
  input  logic [IW-1:0] use_idx,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] age [N];

  always_ff @(posedge clk) begin
    for (int j = 0; j < N; j++) begin
      if (rst) age[j] <= IW'(j);
      else if (use_v) begin
        if (IW'(j) == use_idx) age[j] <= '0;
        else if (age[j] < age[use_idx]) age[j] <= age[j] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int j = 0; j < N; j++)
      if (age[j] == IW'(N - 1)) victim = IW'(j);
  end
endmodule

// File: rtl/pf_cand.sv
module pf_cand #(
  parameter int N  = 4,
  parameter int LW = 25,
  parameter int PB = 5,
  localparam int RW = $clog2(N)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          miss_valid,
  input  logic [LW-1:0] miss_line,
  output logic          hit,
  output logic          hit_dn
);
  logic [LW-1:0] cl [N];
  logic [N-1:0]  cv, hu, hd;
  logic [RW-1:0] rr;

  for (genvar j = 0; j < N; j++) begin : g_cmp
    assign hu[j] = cv[j] && (miss_line[PB-1:0] != '0) && (cl[j] == miss_line - 1'b1);
    assign hd[j] = cv[j] && (miss_line[PB-1:0] != '1) && (cl[j] == miss_line + 1'b1);
  end

  assign hit    = miss_valid && |(hu | hd);
  assign hit_dn = ~|hu;

  always_ff @(posedge clk) begin
    if (rst) begin
      cv <= '0;
      rr <= '0;
    end else if (miss_valid) begin
      if (|(hu | hd)) cv <= cv & ~(hu | hd);
      else begin
        cv[rr] <= 1'b1;
        cl[rr] <= miss_line;
        rr     <= rr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pf_stream_engine.sv
module pf_stream_engine #(
  parameter int LW         = 25,
  parameter int NS         = 16,
  parameter int NC         = 4,
  parameter int PAGE_LINES = 32,
  parameter int L1_AHEAD   = 2,
  parameter int L2_MAX     = 24,
  localparam int SW  = $clog2(NS),
  localparam int DW  = $clog2(L2_MAX + 1),
  localparam int A1W = $clog2(L1_AHEAD + 1),
  localparam int PB  = $clog2(PAGE_LINES)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg_l2_depth,
  input  logic          miss_valid,
  input  logic [LW-1:0] miss_line,
  input  logic          miss_store,
  input  logic          touch_valid,
  input  logic [LW-1:0] touch_line,
  input  logic          sw_valid,
  input  logic          sw_start,
  input  logic [SW-1:0] sw_slot,
  input  logic          sw_desc,
  input  logic          sw_store,
  input  logic [LW-1:0] sw_line,
  input  logic [DW-1:0] sw_len,
  input  logic          pf_ready,
  output logic          pf_valid,
  output logic [LW-1:0] pf_line,
  output logic          pf_l2
);
  import pf_pkg::*;

  // lines left in the page beyond ln, in the stream direction
  function automatic logic [PB-1:0] room_f(input logic [LW-1:0] ln, input logic d);
    return d ? ln[PB-1:0] : ~ln[PB-1:0];
  endfunction

  function automatic logic [DW-1:0] clamp_f(input logic [DW-1:0] v);
    return (int'(v) > L2_MAX) ? DW'(L2_MAX) : v;
  endfunction

  logic [NS-1:0]  vld, st, dn;
  logic [LW-1:0]  head [NS];
  logic [A1W-1:0] a1 [NS];
  logic [DW-1:0]  a2 [NS], dep [NS];

  logic [NS-1:0]  n1, n2, need, thit;
  logic [LW-1:0]  nxt [NS], tgt [NS], kk [NS];
  logic [PB-1:0]  rm [NS];
  logic [A1W-1:0] a1_nx [NS];
  logic [DW-1:0]  a2_nx [NS];

  logic          cand_hit, cand_dn, alloc_go, free_any, iss_any, tch_any, load_go, lru_use;
  logic [SW-1:0] free_idx, victim, alloc_idx, iss_idx, tch_idx, lru_idx;
  pf_level_e     lvl;

  pf_cand #(.N(NC), .LW(LW), .PB(PB)) u_cand (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_line(miss_line),
    .hit(cand_hit), .hit_dn(cand_dn));

  pf_pick #(.N(NS)) u_free (.req(~vld), .any(free_any), .idx(free_idx));
  pf_pick #(.N(NS)) u_iss  (.req(need), .any(iss_any),  .idx(iss_idx));
  pf_pick #(.N(NS)) u_tch  (.req(thit), .any(tch_any),  .idx(tch_idx));

  assign alloc_idx = free_any ? free_idx : victim;
  assign alloc_go  = cand_hit && !sw_valid && (room_f(miss_line, cand_dn) != '0);
  assign load_go   = iss_any && (!pf_valid || pf_ready);
  assign lru_use   = (sw_valid && sw_start) || alloc_go || tch_any;
  assign lru_idx   = (sw_valid && sw_start) ? sw_slot : (alloc_go ? alloc_idx : tch_idx);
  assign lvl       = n1[iss_idx] ? LVL_L1 : LVL_L2;

  pf_lru #(.N(NS)) u_lru (
    .clk(clk), .rst(rst), .use_v(lru_use), .use_idx(lru_idx), .victim(victim));

  for (genvar i = 0; i < NS; i++) begin : g_ent
    logic iss;
    assign iss      = load_go && (iss_idx == SW'(i));
    assign rm[i]    = room_f(head[i], dn[i]);
    assign nxt[i]   = dn[i] ? head[i] - 1'b1 : head[i] + 1'b1;
    assign n1[i]    = !st[i] && (int'(a1[i]) < L1_AHEAD) && (int'(a1[i]) < int'(rm[i]));
    assign n2[i]    = (int'(a2[i]) < int'(dep[i])) && (int'(a2[i]) < int'(rm[i]));
    assign need[i]  = vld[i] && (n1[i] || n2[i]);
    assign kk[i]    = LW'(n1[i] ? int'(a1[i]) + 1 : int'(a2[i]) + 1);
    assign tgt[i]   = dn[i] ? head[i] - kk[i] : head[i] + kk[i];
    assign thit[i]  = vld[i] && touch_valid && (touch_line == nxt[i]);
    assign a1_nx[i] = A1W'(int'(a1[i]) - int'(thit[i] && (a1[i] != '0)) + int'(iss && n1[i]));
    assign a2_nx[i] = DW'(int'(a2[i]) - int'(thit[i] && (a2[i] != '0)) + int'(iss && !n1[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else begin
      for (int i = 0; i < NS; i++) begin
        if (sw_valid && sw_slot == SW'(i)) begin
          vld[i]  <= sw_start && (room_f(sw_line, sw_desc) != '0);
          head[i] <= sw_line;
          dn[i]   <= sw_desc;
          st[i]   <= sw_store;
          a1[i]   <= '0;
          a2[i]   <= '0;
          dep[i]  <= clamp_f(sw_len);
        end else if (alloc_go && alloc_idx == SW'(i)) begin
          vld[i]  <= 1'b1;
          head[i] <= miss_line;
          dn[i]   <= cand_dn;
          st[i]   <= miss_store;
          a1[i]   <= '0;
          a2[i]   <= '0;
          dep[i]  <= clamp_f(cfg_l2_depth);
        end else if (vld[i]) begin
          a1[i] <= a1_nx[i];
          a2[i] <= a2_nx[i];
          if (thit[i]) begin
            head[i] <= nxt[i];
            if (room_f(nxt[i], dn[i]) == '0) vld[i] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pf_valid <= 1'b0;
    else if (!pf_valid || pf_ready) begin
      pf_valid <= iss_any;
      if (iss_any) begin
        pf_line <= tgt[iss_idx];
        pf_l2   <= (lvl == LVL_L2);
      end
    end
  end
endmodule

// File: rtl/pf_stream_engine_chk.sv
module pf_stream_engine_chk #(
  parameter int LW = 25,
  parameter int NS = 16,
  localparam int SW = $clog2(NS)
)(
  input logic          clk,
  input logic          rst,
  input logic          pf_valid,
  input logic          pf_ready,
  input logic [LW-1:0] pf_line,
  input logic          pf_l2,
  input logic          sw_valid,
  input logic          sw_start,
  input logic [SW-1:0] sw_slot,
  input logic [NS-1:0] vld
);
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line) && $stable(pf_l2))); // R7

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pf_valid); // R1

  AST_SW_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (sw_valid && !sw_start) |=> !vld[$past(sw_slot)]); // R9

  AST_REQ_KNOWN: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> !$isunknown({pf_line, pf_l2})); // R3
endmodule

bind pf_stream_engine pf_stream_engine_chk #(.LW(LW), .NS(NS)) u_chk (
  .clk(clk), .rst(rst), .pf_valid(pf_valid), .pf_ready(pf_ready),
  .pf_line(pf_line), .pf_l2(pf_l2), .sw_valid(sw_valid), .sw_start(sw_start),
  .sw_slot(sw_slot), .vld(vld));

// File: tb/pf_stream_engine_test.sv
`timescale 1ns/1ps
module pf_stream_engine_test;
  localparam int LW = 25;
  localparam int NV = 6;
  // vector table: head line, descending, store, depth
  localparam int V_HEAD [NV] = '{325, 650, 963, 1309, 1602, 1921};
  localparam bit V_DN   [NV] = '{0, 1, 0, 0, 1, 0};
  localparam bit V_ST   [NV] = '{0, 0, 1, 0, 0, 0};
  localparam int V_DEP  [NV] = '{4, 3, 5, 6, 31, 31};

  logic clk = 0, rst = 1;
  logic [4:0] cfg_l2_depth = '0;
  logic miss_valid = 0, miss_store = 0, touch_valid = 0;
  logic [LW-1:0] miss_line = '0, touch_line = '0, sw_line = '0;
  logic sw_valid = 0, sw_start = 0, sw_desc = 0, sw_store = 0;
  logic [3:0] sw_slot = '0;
  logic [4:0] sw_len = '0;
  logic pf_ready = 1;
  logic pf_valid, pf_l2;
  logic [LW-1:0] pf_line;

  int checks = 0, fails = 0;
  bit done = 0;
  int gl [64]; bit gb [64]; int gn;
  int el [64]; bit eb [64]; int en;

  always #5 clk = ~clk;

  pf_stream_engine uut (
    .clk(clk), .rst(rst), .cfg_l2_depth(cfg_l2_depth),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_store(miss_store),
    .touch_valid(touch_valid), .touch_line(touch_line),
    .sw_valid(sw_valid), .sw_start(sw_start), .sw_slot(sw_slot), .sw_desc(sw_desc),
    .sw_store(sw_store), .sw_line(sw_line), .sw_len(sw_len),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line), .pf_l2(pf_l2));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic miss(input int ln, input bit s);
    @(negedge clk); miss_valid = 1; miss_line = LW'(ln); miss_store = s;
    @(negedge clk); miss_valid = 0;
  endtask

  task automatic touch(input int ln);
    @(negedge clk); touch_valid = 1; touch_line = LW'(ln);
    @(negedge clk); touch_valid = 0;
  endtask

  task automatic swc(input bit start, input int slot, input bit d, input bit s, input int ln, input int len);
    @(negedge clk);
    sw_valid = 1; sw_start = start; sw_slot = 4'(slot); sw_desc = d;
    sw_store = s; sw_line = LW'(ln); sw_len = 5'(len);
    @(negedge clk); sw_valid = 0;
  endtask

  // samples at the current falling edge first, then each following one
  task automatic collect(input int cyc);
    gn = 0;
    repeat (cyc) begin
      if (pf_valid && pf_ready && gn < 64) begin
        gl[gn] = int'(pf_line); gb[gn] = pf_l2; gn++;
      end
      @(negedge clk);
    end
  endtask

  task automatic build_exp(input int h, input bit d, input bit s, input int dep);
    int off, room, c1, c2, st;
    off  = h % 32;
    room = d ? off : 31 - off;
    st   = d ? -1 : 1;
    c1   = s ? 0 : ((room < 2) ? room : 2);
    if (dep > 24) dep = 24;
    c2   = (dep < room) ? dep : room;
    en = 0;
    for (int k = 1; k <= c1; k++) begin el[en] = h + k * st; eb[en] = 0; en++; end
    for (int k = 1; k <= c2; k++) begin el[en] = h + k * st; eb[en] = 1; en++; end
  endtask

  task automatic exp1(input int ln, input bit lv);
    en = 1; el[0] = ln; eb[0] = lv;
  endtask

  task automatic cmp_seq(input string req, input string tag);
    chk(gn == en, req, {tag, " request count"}, gn, en);
    for (int k = 0; k < gn && k < en; k++)
      chk(gl[k] == el[k] && gb[k] == eb[k], req,
          $sformatf("%s item %0d level act=%0d exp=%0d line", tag, k, gb[k], eb[k]), gl[k], el[k]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    collect(5);
    chk(gn == 0 && !pf_valid, "R1", "requests after reset", gn, 0);

    // R2 R3 R4 R5: vector table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      cfg_l2_depth = 5'(V_DEP[v]);
      miss(V_DN[v] ? V_HEAD[v] + 1 : V_HEAD[v] - 1, V_ST[v]);
      miss(V_HEAD[v], V_ST[v]);
      collect(40);
      build_exp(V_HEAD[v], V_DN[v], V_ST[v], V_DEP[v]);
      cmp_seq(V_ST[v] ? "R4" : (V_DEP[v] > 24 ? "R3" : "R2"), $sformatf("vector %0d", v));
    end

    // R2: a lone miss or a miss two lines away opens nothing
    do_reset();
    cfg_l2_depth = 5'd4;
    miss(500, 0); miss(502, 0);
    collect(10);
    chk(gn == 0, "R2", "requests from non-adjacent misses", gn, 0);

    // R6: touch advances the head; a touch on another line is ignored
    do_reset();
    cfg_l2_depth = 5'd4;
    miss(324, 0); miss(325, 0);
    collect(20);
    touch(326);
    collect(10);
    en = 2; el[0] = 328; eb[0] = 0; el[1] = 330; eb[1] = 1;
    cmp_seq("R6", "after touch");
    touch(330);
    collect(10);
    chk(gn == 0, "R6", "requests after off-stream touch", gn, 0);

    // R7: request held under backpressure
    do_reset();
    cfg_l2_depth = 5'd4;
    pf_ready = 0;
    miss(324, 0); miss(325, 0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk(pf_valid && int'(pf_line) == 326 && !pf_l2, "R7", "held request line", int'(pf_line), 326);
      @(negedge clk);
    end
    pf_ready = 1;
    collect(40);
    build_exp(325, 0, 0, 4);
    cmp_seq("R7", "after release");

    // R5: pair ending on the page's last line, and a pair across pages
    do_reset();
    cfg_l2_depth = 5'd4;
    miss(190, 0); miss(191, 0);
    miss(223, 0); miss(224, 0);
    collect(10);
    chk(gn == 0, "R5", "requests from edge or straddling pairs", gn, 0);

    // R5: touches walking the head to the page edge end the stream
    do_reset();
    swc(1, 0, 0, 0, 252, 0);
    collect(10);
    build_exp(252, 0, 0, 0);
    cmp_seq("R5", "start near edge");
    touch(253); collect(10);
    exp1(255, 0);
    cmp_seq("R5", "touch 253");
    touch(254); collect(10);
    chk(gn == 0, "R5", "requests after touch 254", gn, 0);
    touch(255); collect(10);
    touch(256); collect(10);
    chk(gn == 0, "R5", "requests past page edge", gn, 0);

    // R8: software start, descending store stream, and clamped depth
    do_reset();
    swc(1, 3, 1, 1, 298, 2);
    collect(10);
    build_exp(298, 1, 1, 2);
    cmp_seq("R8", "sw store stream");
    swc(1, 5, 0, 0, 352, 30);
    collect(40);
    build_exp(352, 0, 0, 30);
    cmp_seq("R8", "sw clamped depth");

    // R9: software end silences the slot
    swc(0, 3, 0, 0, 0, 0);
    touch(297);
    collect(10);
    chk(gn == 0, "R9", "requests after end and touch", gn, 0);

    // R10: full table evicts the least recently used slot
    do_reset();
    cfg_l2_depth = 5'd0;
    for (int i = 0; i < 16; i++) swc(1, i, 0, 0, (100 + i) * 32, 0);
    collect(60);
    touch(3201);
    collect(10);
    exp1(3203, 0);
    cmp_seq("R10", "touch slot 0");
    miss(6404, 0); miss(6405, 0);
    collect(10);
    build_exp(6405, 0, 0, 0);
    cmp_seq("R10", "new stream");
    touch(3233);
    collect(10);
    chk(gn == 0, "R10", "requests from evicted stream", gn, 0);
    touch(3265);
    collect(10);
    exp1(3267, 0);
    cmp_seq("R10", "surviving stream");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule